// File: doc/BRIEF.md
# 1-Wire Bus Master Time-Slot Engine

This block is a hardware master for a 1-Wire bus. It produces the read and write time slots itself, so software does not have to hold interrupts off while a slot runs. All slot timing counts in microsecond units. A programmable divider turns the system clock into these units, so one design keeps its timing across system clocks from about 1 MHz to 75 MHz. The engine pulls the open-drain line low through `bus_drive_low` and reads the line level back on `bus_in`.

Software uses a small register window that it reaches indirectly. It first writes a register number to the address port. It then reads or writes that register through the data port. The window holds a control register, a transmit buffer, a receive buffer, a flag register and the divider. In single-bit mode, each write to the transmit buffer runs one slot. In byte mode, each write runs eight slots, least significant bit first. Either way, the sampled bits land in the receive buffer and a full flag is raised.

Top module: `owire_slot_engine`

## Requirements
- R1: A write strobe on the address port stores `wr_data[2:0]` as the selected register. `rd_data` shows that register. Register 0 is control, where bit 0 = 1 selects single-bit mode. Register 1 is the transmit buffer and reads 0. Register 2 is the receive buffer. Register 3 holds the flags: bit 0 is receive-full and bit 1 is busy. Register 4 is the divider. Addresses 5 to 7 read 0.
- R2: After reset the bus is released. Control reads 0, which means byte mode. The flags and the receive buffer read 0. The divider reads DIV_RESET, which is 9 by default.
- R3: One microsecond unit lasts divider+1 system clock cycles, and all slot timing counts in these units.
- R4: Every slot starts by pulling the bus low. For a transmitted 1, the bus is released after exactly 5 units.
- R5: For a transmitted 0, the bus is held low for exactly 60 units.
- R6: The engine samples the line 15 units after the slot starts. The received bit is the sampled line level.
- R7: A slot lasts 61 units, and at least the last unit leaves the bus released. Back-to-back slots in byte mode start 61×(divider+1)+1 cycles apart.
- R8: In single-bit mode, one transmit write runs exactly one slot using bit 0 of the written value. The receive buffer then holds the sampled bit in bit 0 with zeros above it, and receive-full is set.
- R9: In byte mode, one transmit write runs eight slots that send bits 0 to 7 in order. Sampled bit k lands in receive bit k, and receive-full is set only after the eighth slot.
- R10: A data-port read of the receive buffer clears receive-full.
- R11: While busy, a write to the transmit buffer is ignored: no extra slots are run and the result is not changed. The busy flag reads 1 during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_we | input | 1 | Strobe that loads the register number from wr_data |
| data_we | input | 1 | Strobe that writes wr_data to the selected register |
| data_re | input | 1 | Strobe marking a data-port read (used to clear receive-full) |
| wr_data | input | 8 | Write value for the address or data port |
| rd_data | output | 8 | Contents of the selected register |
| bus_in | input | 1 | Level of the 1-Wire line |
| bus_drive_low | output | 1 | 1 pulls the open-drain line low |

## Verification
A fault in the microsecond counter or the divider shows up on `bus_drive_low` during the very first slot. The low pulse becomes longer or shorter than 5 or 60 whole units, and the time between slot starts stops being 61 units plus one cycle. A fault in the transfer controller's bit count or shift state shows up when the transfer completes. The slot count per transmit write changes, or the bits in the receive buffer come out in the wrong order, the moment receive-full rises. A wrong sample point only shows up when the slave's pull-down does not cover the sample instant. For that reason the slave model holds the line for a fixed window, and the checks compare the received value with the transmitted AND slave bits.

// File: rtl/owm_pkg.sv
package owm_pkg;

   typedef enum logic [2:0] {
      REG_CTRL  = 3'd0,
      REG_TX    = 3'd1,
      REG_RX    = 3'd2,
      REG_FLAGS = 3'd3,
      REG_DIV   = 3'd4
   } owm_reg_e;

   localparam int CTRL_SINGLE_BIT = 0;
   localparam int FLAG_RXF_BIT    = 0;
   localparam int FLAG_BUSY_BIT   = 1;

endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt >= div) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt >= div);

   // R3: the prescaler never runs past the programmed divide
   a_r3_cnt_bounded : assert property (@(posedge clk) disable iff (!rst_n)
      (run && $stable(div)) |-> (cnt <= div));

   // R3: a tick is always followed by a counter restart
   a_r3_tick_restart : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run) |=> (cnt == '0));

endmodule

// File: rtl/owm_slot_gen.sv
module owm_slot_gen #(
   parameter int LOW_US      = 5,
   parameter int SAMPLE_US   = 15,
   parameter int HOLD_US     = 60,
   parameter int SLOT_US     = 61,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tx_bit,
   input  logic tick,
   input  logic bus_in,
   output logic active,
   output logic drive_low,
   output logic done,
   output logic rx_bit
);

   localparam int US_W = $clog2(SLOT_US + 1);
   localparam logic [US_W-1:0] LOW_T       = US_W'(LOW_US);
   localparam logic [US_W-1:0] HOLD_T      = US_W'(HOLD_US);
   localparam logic [US_W-1:0] SAMPLE_LAST = US_W'(SAMPLE_US - 1);
   localparam logic [US_W-1:0] SLOT_LAST   = US_W'(SLOT_US - 1);

   generate
      if (!(LOW_US >= 1 && LOW_US < SAMPLE_US && SAMPLE_US < HOLD_US && HOLD_US < SLOT_US)) begin : g_bad_timing
         $error("slot timing must satisfy 1 <= LOW < SAMPLE < HOLD < SLOT");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic bus_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign bus_s = bus_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk) begin
            if (!rst_n) sr <= '1;
            else begin
               sr[0] <= bus_in;
               for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign bus_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   logic [US_W-1:0] us;
   logic            bit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         us     <= '0;
         bit_q  <= 1'b1;
         rx_bit <= 1'b0;
      end else if (!active) begin
         if (start) begin
            active <= 1'b1;
            us     <= '0;
            bit_q  <= tx_bit;
         end
      end else if (tick) begin
         if (us == SAMPLE_LAST) rx_bit <= bus_s;
         if (us == SLOT_LAST) begin
            active <= 1'b0;
            us     <= '0;
         end else begin
            us <= us + 1'b1;
         end
      end
   end

   assign done      = active && tick && (us == SLOT_LAST);
   assign drive_low = active && ((us < LOW_T) || (!bit_q && (us < HOLD_T)));

   // R4: a slot opens with the line pulled low
   a_r4_low_at_start : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> drive_low);

   // R7: the final unit of every slot is a recovery unit
   a_r7_recovery : assert property (@(posedge clk) disable iff (!rst_n)
      (active && us == SLOT_LAST) |-> !drive_low);

   // R7: the unit counter stays inside the slot
   a_r7_us_range : assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (us <= SLOT_LAST));

   // R7: completion closes the slot on the next cycle
   a_r7_done_closes : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !active);

endmodule

// File: rtl/owm_xfer_ctl.sv
module owm_xfer_ctl #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] go_data,
   input  logic         single,
   input  logic         slot_active,
   input  logic         slot_done,
   input  logic         slot_rx,
   output logic         start,
   output logic         tx_bit,
   output logic         busy,
   output logic         rx_load,
   output logic [W-1:0] rx_value
);

   localparam int LEFT_W = $clog2(W + 1);
   localparam logic [LEFT_W-1:0] ONE_LEFT = LEFT_W'(1);
   localparam logic [LEFT_W-1:0] ALL_LEFT = LEFT_W'(W);

   generate
      if (W < 2) begin : g_bad_width
         $error("transfer width must be at least 2");
      end
   endgenerate

   logic [LEFT_W-1:0] left;
   logic [W-1:0]      tx_sh;
   logic [W-1:0]      rx_sh;
   logic              single_q;
   logic              start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         left     <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         single_q <= 1'b0;
         start_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (!busy) begin
            if (go) begin
               busy     <= 1'b1;
               tx_sh    <= go_data;
               left     <= single ? ONE_LEFT : ALL_LEFT;
               single_q <= single;
               start_q  <= 1'b1;
            end
         end else if (slot_done) begin
            rx_sh <= {slot_rx, rx_sh[W-1:1]};
            if (left == ONE_LEFT) begin
               busy <= 1'b0;
               left <= '0;
            end else begin
               left    <= left - 1'b1;
               tx_sh   <= {1'b0, tx_sh[W-1:1]};
               start_q <= 1'b1;
            end
         end
      end
   end

   assign start    = start_q;
   assign tx_bit   = tx_sh[0];
   assign rx_load  = busy && slot_done && (left == ONE_LEFT);
   assign rx_value = single_q ? {{(W-1){1'b0}}, slot_rx} : {slot_rx, rx_sh[W-1:1]};

   // R9: a new slot is never requested while one is still running
   a_r9_start_idle : assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !slot_active);

   // R9: the remaining-bit count stays within one transfer
   a_r9_left_range : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (left >= ONE_LEFT && left <= ALL_LEFT));

   // R11: a transfer cannot be ended except by a slot completion
   a_r11_busy_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !slot_done) |=> busy);

endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine #(
   parameter int           DATA_W      = 8,
   parameter int           DIV_W       = 8,
   parameter logic [7:0]   DIV_RESET   = 8'd9,
   parameter int           LOW_US      = 5,
   parameter int           SAMPLE_US   = 15,
   parameter int           HOLD_US     = 60,
   parameter int           SLOT_US     = 61,
   parameter int           SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic              data_we,
   input  logic              data_re,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              bus_in,
   output logic              bus_drive_low
);
   import owm_pkg::*;

   generate
      if (DIV_W > DATA_W || DIV_W > 8 || DATA_W < 3) begin : g_bad_widths
         $error("need 3 <= DATA_W and DIV_W <= min(DATA_W, 8)");
      end
   endgenerate

   logic [2:0]        addr_q;
   logic              ctrl_single;
   logic [DIV_W-1:0]  div_q;
   logic [DATA_W-1:0] rx_buf;
   logic              rxf;

   logic tick, slot_active, slot_drive, slot_done, slot_rx;
   logic start, tx_bit, busy, rx_load;
   logic [DATA_W-1:0] rx_value;

   logic sel_ctrl, sel_tx, sel_rx, sel_div;
   assign sel_ctrl = (addr_q == REG_CTRL);
   assign sel_tx   = (addr_q == REG_TX);
   assign sel_rx   = (addr_q == REG_RX);
   assign sel_div  = (addr_q == REG_DIV);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q      <= '0;
         ctrl_single <= 1'b0;
         div_q       <= DIV_W'(DIV_RESET);
         rx_buf      <= '0;
         rxf         <= 1'b0;
      end else begin
         if (addr_we) addr_q <= wr_data[2:0];
         if (data_we && sel_ctrl) ctrl_single <= wr_data[CTRL_SINGLE_BIT];
         if (data_we && sel_div)  div_q <= wr_data[DIV_W-1:0];
         if (rx_load) begin
            rx_buf <= rx_value;
            rxf    <= 1'b1;
         end else if (data_re && sel_rx) begin
            rxf <= 1'b0;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (addr_q)
         REG_CTRL:  rd_data[CTRL_SINGLE_BIT] = ctrl_single;
         REG_RX:    rd_data = rx_buf;
         REG_FLAGS: begin
            rd_data[FLAG_RXF_BIT]  = rxf;
            rd_data[FLAG_BUSY_BIT] = busy;
         end
         REG_DIV:   rd_data[DIV_W-1:0] = div_q;
         default:   rd_data = '0;
      endcase
   end

   owm_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (slot_active),
      .div   (div_q),
      .tick  (tick)
   );

   owm_slot_gen #(
      .LOW_US      (LOW_US),
      .SAMPLE_US   (SAMPLE_US),
      .HOLD_US     (HOLD_US),
      .SLOT_US     (SLOT_US),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .tx_bit    (tx_bit),
      .tick      (tick),
      .bus_in    (bus_in),
      .active    (slot_active),
      .drive_low (slot_drive),
      .done      (slot_done),
      .rx_bit    (slot_rx)
   );

   owm_xfer_ctl #(.W(DATA_W)) u_xfer (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (data_we && sel_tx),
      .go_data     (wr_data),
      .single      (ctrl_single),
      .slot_active (slot_active),
      .slot_done   (slot_done),
      .slot_rx     (slot_rx),
      .start       (start),
      .tx_bit      (tx_bit),
      .busy        (busy),
      .rx_load     (rx_load),
      .rx_value    (rx_value)
   );

   assign bus_drive_low = slot_drive;

   // R8: a completed transfer raises receive-full on the next cycle
   a_r8_rxf_set : assert property (@(posedge clk) disable iff (!rst_n)
      rx_load |=> rxf);

   // R10: reading the receive buffer drops receive-full
   a_r10_rxf_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (data_re && sel_rx && !rx_load) |=> !rxf);

   // R9: receive-full only rises when a transfer finishes
   a_r9_rxf_rise : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxf) |-> $past(rx_load));

   // R2: the bus is never pulled while no slot runs
   a_r2_idle_released : assert property (@(posedge clk) disable iff (!rst_n)
      !slot_active |-> !bus_drive_low);

endmodule

// File: tb/owire_slot_engine_bench.sv
module owire_slot_engine_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_we = 1'b0, data_we = 1'b0, data_re = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       bus_in;
   logic       bus_drive_low;

   always #(CLK_PERIOD/2) clk = ~clk;

   owire_slot_engine u_owire_slot_engine (
      .clk           (clk),
      .rst_n         (rst_n),
      .addr_we       (addr_we),
      .data_we       (data_we),
      .data_re       (data_re),
      .wr_data       (wr_data),
      .rd_data       (rd_data),
      .bus_in        (bus_in),
      .bus_drive_low (bus_drive_low)
   );

   // bench-side slave and line monitor
   int         cyc = 0;
   int         slot_idx = 0;
   int         wid [256];
   int         st  [256];
   int         cur_start = 0;
   int         slave_cnt = 0;
   logic       prev_drive = 1'b0;
   int         base = 0;
   int         cur_div = 9;
   logic [7:0] slave_byte = 8'hFF;

   assign bus_in = !(bus_drive_low || (slave_cnt != 0));

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (bus_drive_low && !prev_drive) begin
         st[slot_idx & 255] <= cyc;
         cur_start <= cyc;
         if (!slave_byte[(slot_idx - base) & 7]) slave_cnt <= 30 * (cur_div + 1);
      end else if (slave_cnt > 0) begin
         slave_cnt <= slave_cnt - 1;
      end
      if (!bus_drive_low && prev_drive) begin
         wid[slot_idx & 255] <= cyc - cur_start;
         slot_idx <= slot_idx + 1;
      end
      prev_drive <= bus_drive_low;
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_addr(input logic [7:0] a);
      @(negedge clk); addr_we = 1'b1; wr_data = a;
      @(negedge clk); addr_we = 1'b0;
   endtask

   task automatic put_data(input logic [7:0] v);
      @(negedge clk); data_we = 1'b1; wr_data = v;
      @(negedge clk); data_we = 1'b0;
   endtask

   task automatic get_reg(input logic [7:0] a, input bit clr, output logic [7:0] v);
      set_addr(a);
      v = rd_data;
      data_re = clr;
      @(negedge clk); data_re = 1'b0;
   endtask

   task automatic set_div(input int d);
      set_addr(8'd4); put_data(8'(d));
      cur_div = d;
   endtask

   task automatic set_mode(input bit single);
      set_addr(8'd0); put_data({7'b0, single});
   endtask

   function automatic logic [7:0] exp_rx(input bit single, input logic [7:0] tx, input logic [7:0] sl);
      if (single) return {7'b0, tx[0] & sl[0]};
      return tx & sl;
   endfunction

   task automatic wait_full(output bit got);
      logic [7:0] f;
      got = 1'b0;
      for (int k = 0; k < 20000 && !got; k++) begin
         get_reg(8'd3, 1'b0, f);
         got = f[0];
      end
   endtask

   // one transfer; probe_busy writes a second value while the first runs
   task automatic xfer(input bit single, input logic [7:0] tx, input logic [7:0] sl, input bit probe_busy);
      bit got;
      logic [7:0] v;
      int n_exp;
      n_exp = single ? 1 : 8;
      @(negedge clk);
      slave_byte = sl;
      base = slot_idx;
      set_addr(8'd1); put_data(tx);
      if (probe_busy) begin
         repeat (20) @(negedge clk);
         get_reg(8'd3, 1'b0, v);
         check("R11 busy flag", int'(v[1]), 1);
         set_addr(8'd1); put_data(~tx);
      end
      wait_full(got);
      check("R8 R9 receive-full raised", int'(got), 1);
      repeat (4) @(negedge clk);
      check(single ? "R8 slot count" : "R9 R11 slot count", slot_idx - base, n_exp);
      for (int i = 0; i < n_exp; i++) begin
         check(tx[i] ? "R3 R4 low width for 1" : "R3 R5 low width for 0",
               wid[(base + i) & 255], (tx[i] ? 5 : 60) * (cur_div + 1));
         if (i > 0)
            check("R7 slot spacing", st[(base + i) & 255] - st[(base + i - 1) & 255],
                  61 * (cur_div + 1) + 1);
      end
      get_reg(8'd2, 1'b1, v);
      check(single ? "R6 R8 received bit" : "R6 R9 R11 received byte", int'(v), int'(exp_rx(single, tx, sl)));
      get_reg(8'd3, 1'b0, v);
      check("R10 receive-full cleared", int'(v[0]), 0);
      check("R11 busy clear at end", int'(v[1]), 0);
   endtask

   initial begin
      logic [7:0] v;
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      check("R2 bus released in reset", int'(bus_drive_low), 0);
      @(negedge clk); rst_n = 1'b1;

      get_reg(8'd0, 1'b0, v); check("R2 control reset", int'(v), 0);
      get_reg(8'd3, 1'b0, v); check("R2 flags reset", int'(v), 0);
      get_reg(8'd2, 1'b0, v); check("R2 receive reset", int'(v), 0);
      get_reg(8'd4, 1'b0, v); check("R2 divider reset", int'(v), 9);

      set_mode(1'b1);
      get_reg(8'd0, 1'b0, v); check("R1 control readback", int'(v), 1);
      get_reg(8'd6, 1'b0, v); check("R1 unused address", int'(v), 0);
      get_reg(8'd1, 1'b0, v); check("R1 transmit reads zero", int'(v), 0);
      set_div(1);
      get_reg(8'd4, 1'b0, v); check("R1 divider readback", int'(v), 1);

      // directed single-bit slots
      xfer(1'b1, 8'h01, 8'h00, 1'b0);
      xfer(1'b1, 8'h01, 8'hFF, 1'b0);
      xfer(1'b1, 8'hFE, 8'hFF, 1'b0);

      // directed byte transfers
      set_mode(1'b0);
      xfer(1'b0, 8'hA5, 8'hFF, 1'b0);
      xfer(1'b0, 8'hFF, 8'h3C, 1'b0);
      set_div(4);
      xfer(1'b0, 8'h81, 8'hF0, 1'b0);
      xfer(1'b0, 8'h5A, 8'hFF, 1'b1);

      // random transfers
      for (int t = 0; t < 8; t++) begin
         bit sm;
         sm = 1'($urandom_range(0, 1));
         set_div(int'($urandom_range(0, 3)));
         set_mode(sm);
         xfer(sm, 8'($urandom), 8'($urandom), 1'($urandom_range(0, 1)));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad + 1);
      $finish;
   end

endmodule